// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits next to one processor core and decides which interrupt, if any, is offered to it. It keeps a 32-bit presentation register whose upper byte is the core's current priority threshold and whose lower 24 bits name the source being offered. A zero source field means nothing is offered. Alongside that register it keeps the priority of the offered source and the priority of a pending inter-processor interrupt (IPI). Lower numbers are more favored, and 0xFF is the least favored value.

Source controllers present requests, each carrying a source number and a priority. The block either takes a request or bounces it back with a reject pulse. A better request displaces a weaker one that is already offered, and the displaced source is rejected so that its owner can resend it later. A pending IPI competes with device interrupts on priority and uses the fixed source number 2. The core works through five register operations: accept, poll, set threshold, set IPI priority and end-of-interrupt. Toward the source side the block emits reject, resend and end-of-interrupt pulses. All results are registered and appear one clock after the stimulus.

Top module: `irq_presenter`

## Requirements
- R1: A poll (op code 1) returns the presentation register {threshold[31:24], source[23:0]} on `rd_data` and the IPI priority on `rd_ipi_prio`, with `rd_valid` high for one cycle, one clock after the operation. Reject, resend and end-of-interrupt notifications are single-cycle pulses that appear one clock after their cause.
- R2: After a synchronous reset the presentation register reads 0, the IPI priority reads 0xFF, `irq_out` is low and no notification pulses.
- R3: A request is rejected, with its own source number on `rej_src`, when its priority is not numerically below the threshold, or when a source is already offered whose priority is numerically less than or equal to the request's. A request may only be presented in a cycle with no register operation, and only with a nonzero source number.
- R4: A request that is not rejected becomes the offered source with its priority, and `irq_out` rises. If a device source was offered before, that source is rejected. A displaced IPI is not rejected.
- R5: Accept (op code 0) returns the whole presentation register and lowers `irq_out`. It then loads the threshold with the offered priority, clears the source field and sets the offered priority to 0xFF.
- R6: Set threshold (op code 2, value in bits 7:0) with a value below the old threshold drops an offered source whose priority is greater than or equal to the new value. A drop clears the source field, lowers `irq_out` and rejects a device source. An offered source with a priority below the new value is kept.
- R7: Set threshold with a value greater than or equal to the old threshold requests a resend when nothing is offered, and requests none when something is.
- R8: Set IPI priority (op code 3, value in bits 7:0) stores the value. When the value is below the threshold, and no source with a priority less than or equal to it is offered, the IPI becomes the offered source (number 2) at that priority and `irq_out` rises. Any offered device source is then rejected.
- R9: End-of-interrupt (op code 4) loads the threshold from bits 31:24 of the written value and pulses `eoi_src` with bits 23:0. If nothing is offered, a resend is requested.
- R10: Every resend request first loads the stored IPI as the offered source when the IPI priority is below the (new) threshold.
- R11: Op codes 5 to 7 change no state and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Presentation request from a source controller |
| req_src | input | 24 | Source number of the request (nonzero) |
| req_prio | input | 8 | Priority of the request |
| op_valid | input | 1 | Register operation strobe |
| op_code | input | 3 | 0 accept, 1 poll, 2 set threshold, 3 set IPI priority, 4 end-of-interrupt |
| op_data | input | 32 | Operand of the register operation |
| rd_valid | output | 1 | Read result valid (accept or poll) |
| rd_data | output | 32 | Presentation register value returned |
| rd_ipi_prio | output | 8 | IPI priority returned with a read |
| irq_out | output | 1 | Interrupt line to the core |
| rej_valid | output | 1 | Reject pulse toward the source side |
| rej_src | output | 24 | Rejected source number |
| resend_valid | output | 1 | Resend request pulse |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_src | output | 24 | Source number being ended |

## Verification
Every result of this block, whether read data, interrupt line, reject, resend or end-of-interrupt, is registered once and so belongs to the clock edge that captures the stimulus. The bench drives each request or operation on a falling edge, waits for the next rising edge plus a small delay, and samples all outputs in that window before it clears the inputs. Pulses are checked there, and also checked to be absent there when a rule says no notification is due. State that a rule leaves untouched is then read back with a poll one clock later.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  typedef enum logic [2:0] {
    OP_ACCEPT  = 3'd0,
    OP_POLL    = 3'd1,
    OP_SET_CUR = 3'd2,
    OP_SET_IPI = 3'd3,
    OP_EOI     = 3'd4
  } irqp_op_e;
endpackage

// File: rtl/irqp_admit.sv
module irqp_admit #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              busy,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] req_prio,
  output logic              take
);
  logic beats_threshold;
  logic beats_pending;

  always_comb begin
    beats_threshold = req_prio < cur_prio;
    beats_pending   = !busy || (req_prio < pend_prio);
    take            = beats_threshold && beats_pending;
  end
endmodule

// File: rtl/irqp_ipi_eval.sv
module irqp_ipi_eval #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              busy,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              fire
);
  logic held_off;

  always_comb begin
    held_off = busy && (pend_prio <= ipi_prio);
    fire     = (ipi_prio < cur_prio) && !held_off;
  end
endmodule

// File: rtl/irqp_notify.sv
module irqp_notify #(
  parameter int SRC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rej_req,
  input  logic [SRC_W-1:0] rej_num,
  input  logic             resend_req,
  input  logic             eoi_req,
  input  logic [SRC_W-1:0] eoi_num,
  output logic             rej_valid,
  output logic [SRC_W-1:0] rej_src,
  output logic             resend_valid,
  output logic             eoi_valid,
  output logic [SRC_W-1:0] eoi_src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rej_valid    <= 1'b0;
      rej_src      <= '0;
      resend_valid <= 1'b0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
    end else begin
      rej_valid    <= rej_req;
      resend_valid <= resend_req;
      eoi_valid    <= eoi_req;
      if (rej_req) rej_src <= rej_num;
      if (eoi_req) eoi_src <= eoi_num;
    end
  end

  // R2: no notification leaves the block in the cycle after reset
  p_reset_quiet_r2: assert property (@(posedge clk)
    rst |=> (!rej_valid && !resend_valid && !eoi_valid));
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [SRC_W-1:0]          req_src,
  input  logic [PRIO_W-1:0]         req_prio,
  input  logic                      op_valid,
  input  logic [2:0]                op_code,
  input  logic [SRC_W+PRIO_W-1:0]   op_data,
  output logic                      rd_valid,
  output logic [SRC_W+PRIO_W-1:0]   rd_data,
  output logic [PRIO_W-1:0]         rd_ipi_prio,
  output logic                      irq_out,
  output logic                      rej_valid,
  output logic [SRC_W-1:0]          rej_src,
  output logic                      resend_valid,
  output logic                      eoi_valid,
  output logic [SRC_W-1:0]          eoi_src
);
  import irqp_pkg::*;

  localparam int REG_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] LEAST = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);

  // presentation state
  logic [PRIO_W-1:0] cur_q, cur_n;
  logic [SRC_W-1:0]  src_q, src_n;
  logic [PRIO_W-1:0] pend_q, pend_n;
  logic [PRIO_W-1:0] ipi_q, ipi_n;
  logic              own_q, own_n;
  logic              irq_q, irq_n;

  // read port
  logic              rd_load;

  // notifications
  logic              rej_req, resend_req, eoi_req;
  logic [SRC_W-1:0]  rej_num, eoi_num;

  logic              busy;
  logic              take;
  logic              ipi_fire;
  logic [PRIO_W-1:0] ipi_probe;
  logic [PRIO_W-1:0] cur_probe;
  logic [PRIO_W-1:0] op_prio;
  irqp_op_e          op;

  assign busy    = (src_q != '0);
  assign op      = irqp_op_e'(op_code);
  assign op_prio = op_data[PRIO_W-1:0];

  irqp_admit #(.PRIO_W(PRIO_W)) u_admit (
    .cur_prio  (cur_q),
    .busy      (busy),
    .pend_prio (pend_q),
    .req_prio  (req_prio),
    .take      (take)
  );

  // IPI probe: the new value on a write, the stored value on a resend;
  // the threshold it is compared with is the one in force after the op.
  always_comb begin
    ipi_probe = ipi_q;
    cur_probe = cur_q;
    if (op_valid) begin
      case (op)
        OP_SET_IPI: ipi_probe = op_prio;
        OP_SET_CUR: cur_probe = op_prio;
        OP_EOI:     cur_probe = op_data[REG_W-1:SRC_W];
        default:    ;
      endcase
    end
  end

  irqp_ipi_eval #(.PRIO_W(PRIO_W)) u_ipi (
    .ipi_prio  (ipi_probe),
    .cur_prio  (cur_probe),
    .busy      (busy),
    .pend_prio (pend_q),
    .fire      (ipi_fire)
  );

  always_comb begin
    cur_n      = cur_q;
    src_n      = src_q;
    pend_n     = pend_q;
    ipi_n      = ipi_q;
    own_n      = own_q;
    irq_n      = irq_q;
    rd_load    = 1'b0;
    rej_req    = 1'b0;
    rej_num    = '0;
    resend_req = 1'b0;
    eoi_req    = 1'b0;
    eoi_num    = '0;

    if (req_valid) begin
      if (take) begin
        if (busy && own_q) begin
          rej_req = 1'b1;
          rej_num = src_q;
        end
        src_n  = req_src;
        pend_n = req_prio;
        own_n  = 1'b1;
        irq_n  = 1'b1;
      end else begin
        rej_req = 1'b1;
        rej_num = req_src;
      end
    end else if (op_valid) begin
      case (op)
        OP_ACCEPT: begin
          rd_load = 1'b1;
          cur_n   = pend_q;
          src_n   = '0;
          pend_n  = LEAST;
          own_n   = 1'b0;
          irq_n   = 1'b0;
        end
        OP_POLL: rd_load = 1'b1;
        OP_SET_CUR: begin
          cur_n = op_prio;
          if (op_prio < cur_q) begin
            if (busy && (op_prio <= pend_q)) begin
              src_n  = '0;
              pend_n = LEAST;
              own_n  = 1'b0;
              irq_n  = 1'b0;
              if (own_q) begin
                rej_req = 1'b1;
                rej_num = src_q;
              end
            end
          end else if (!busy) begin
            resend_req = 1'b1;
            if (ipi_fire) begin
              src_n  = IPI_NUM;
              pend_n = ipi_q;
              own_n  = 1'b0;
              irq_n  = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          ipi_n = op_prio;
          if (ipi_fire) begin
            if (busy && own_q) begin
              rej_req = 1'b1;
              rej_num = src_q;
            end
            src_n  = IPI_NUM;
            pend_n = op_prio;
            own_n  = 1'b0;
            irq_n  = 1'b1;
          end
        end
        OP_EOI: begin
          cur_n   = op_data[REG_W-1:SRC_W];
          eoi_req = 1'b1;
          eoi_num = op_data[SRC_W-1:0];
          if (!busy) begin
            resend_req = 1'b1;
            if (ipi_fire) begin
              src_n  = IPI_NUM;
              pend_n = ipi_q;
              own_n  = 1'b0;
              irq_n  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q       <= '0;
      src_q       <= '0;
      pend_q      <= LEAST;
      ipi_q       <= LEAST;
      own_q       <= 1'b0;
      irq_q       <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      rd_ipi_prio <= LEAST;
    end else begin
      cur_q    <= cur_n;
      src_q    <= src_n;
      pend_q   <= pend_n;
      ipi_q    <= ipi_n;
      own_q    <= own_n;
      irq_q    <= irq_n;
      rd_valid <= rd_load;
      if (rd_load) begin
        rd_data     <= {cur_q, src_q};
        rd_ipi_prio <= ipi_q;
      end
    end
  end

  assign irq_out = irq_q;

  irqp_notify #(.SRC_W(SRC_W)) u_notify (
    .clk          (clk),
    .rst          (rst),
    .rej_req      (rej_req),
    .rej_num      (rej_num),
    .resend_req   (resend_req),
    .eoi_req      (eoi_req),
    .eoi_num      (eoi_num),
    .rej_valid    (rej_valid),
    .rej_src      (rej_src),
    .resend_valid (resend_valid),
    .eoi_valid    (eoi_valid),
    .eoi_src      (eoi_src)
  );

  // R3: usage rules on the request port
  p_inputs_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && op_valid));
  p_src_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_src != '0));

  // R4: the line follows the presence of an offered source
  p_irq_tracks_src_r4: assert property (@(posedge clk) disable iff (rst)
    irq_q == (src_q != '0));
  // R4: a taken request becomes the offered source
  p_take_loads_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && take) |=> (irq_q && src_q == $past(req_src)));

  // R5: with nothing offered the offered priority is the least favored
  p_idle_pend_least_r5: assert property (@(posedge clk) disable iff (rst)
    (src_q == '0) |-> (pend_q == LEAST));
  // R5: accept lowers the line and empties the source field
  p_accept_lowers_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !req_valid && op == OP_ACCEPT) |=> (!irq_q && src_q == '0));

  // R8: an IPI write below the threshold with nothing offered loads the IPI
  p_ipi_load_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !req_valid && op == OP_SET_IPI && !busy && op_prio < cur_q)
    |=> (src_q == IPI_NUM && irq_q));
endmodule

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [23:0] req_src;
  logic [7:0]  req_prio;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] op_data;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [7:0]  rd_ipi_prio;
  logic        irq_out;
  logic        rej_valid;
  logic [23:0] rej_src;
  logic        resend_valid;
  logic        eoi_valid;
  logic [23:0] eoi_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [2:0] C_ACCEPT = 3'd0, C_POLL = 3'd1, C_CUR = 3'd2,
                         C_IPI = 3'd3, C_EOI = 3'd4;

  always #2 clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ipi_prio(rd_ipi_prio),
    .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
    .resend_valid(resend_valid), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] c, input logic [31:0] d);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_data = d;
    @(posedge clk); #1;
    op_valid = 1'b0; op_code = '0; op_data = '0;
  endtask

  task automatic do_req(input logic [23:0] s, input logic [7:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_src = s; req_prio = p;
    @(posedge clk); #1;
    req_valid = 1'b0; req_src = '0; req_prio = '0;
  endtask

  task automatic poll_expect(input string tag, input logic [31:0] exp_reg, input logic [7:0] exp_ipi);
    do_op(C_POLL, 32'h0);
    chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
    chk({tag, " register"}, rd_data, exp_reg);
    chk({tag, " ipi prio"}, 32'(rd_ipi_prio), 32'(exp_ipi));
  endtask

  task automatic t_reset;
    chk("R2 irq after reset", 32'(irq_out), 32'd0);
    chk("R2 no reject after reset", 32'(rej_valid), 32'd0);
    chk("R2 no resend after reset", 32'(resend_valid), 32'd0);
    poll_expect("R2 R1 reset poll", 32'h0000_0000, 8'hFF);
  endtask

  task automatic t_reject_threshold;
    do_req(24'h10, 8'h05);
    chk("R3 reject at threshold 0", 32'(rej_valid), 32'd1);
    chk("R3 rejected number", 32'(rej_src), 32'h10);
    chk("R3 irq stays low", 32'(irq_out), 32'd0);
    do_op(C_CUR, 32'hFF);
    chk("R7 resend on less favored threshold, empty", 32'(resend_valid), 32'd1);
    chk("R10 no IPI with IPI prio FF", 32'(irq_out), 32'd0);
  endtask

  task automatic t_take_displace;
    do_req(24'h10, 8'h05);
    chk("R4 take raises irq", 32'(irq_out), 32'd1);
    chk("R4 no reject on take into empty", 32'(rej_valid), 32'd0);
    poll_expect("R4 R1 taken", 32'hFF00_0010, 8'hFF);
    do_req(24'h20, 8'h03);
    chk("R4 displaced source rejected", 32'(rej_valid), 32'd1);
    chk("R4 displaced number", 32'(rej_src), 32'h10);
    poll_expect("R4 displaced poll", 32'hFF00_0020, 8'hFF);
    do_req(24'h30, 8'h03);
    chk("R3 equal to pending rejected", 32'(rej_valid), 32'd1);
    chk("R3 equal-prio number", 32'(rej_src), 32'h30);
    do_req(24'h31, 8'h04);
    chk("R3 weaker than pending number", 32'(rej_src), 32'h31);
    poll_expect("R3 pending kept", 32'hFF00_0020, 8'hFF);
  endtask

  task automatic t_accept_eoi;
    do_op(C_ACCEPT, 32'h0);
    chk("R5 accept rd_valid", 32'(rd_valid), 32'd1);
    chk("R5 accept value", rd_data, 32'hFF00_0020);
    chk("R5 accept lowers irq", 32'(irq_out), 32'd0);
    poll_expect("R5 after accept", 32'h0300_0000, 8'hFF);
    do_op(C_EOI, 32'hFF00_0020);
    chk("R9 eoi pulse", 32'(eoi_valid), 32'd1);
    chk("R9 eoi number", 32'(eoi_src), 32'h20);
    chk("R9 resend when empty", 32'(resend_valid), 32'd1);
    poll_expect("R9 threshold restored", 32'hFF00_0000, 8'hFF);
  endtask

  task automatic t_threshold_drop;
    do_req(24'h40, 8'h08);
    chk("R4 take 0x40", 32'(irq_out), 32'd1);
    do_op(C_CUR, 32'h06);
    chk("R6 drop rejects", 32'(rej_valid), 32'd1);
    chk("R6 dropped number", 32'(rej_src), 32'h40);
    chk("R6 drop lowers irq", 32'(irq_out), 32'd0);
    poll_expect("R6 after drop", 32'h0600_0000, 8'hFF);
    do_op(C_CUR, 32'hFF);
    chk("R7 resend", 32'(resend_valid), 32'd1);
    do_req(24'h41, 8'h02);
    do_op(C_CUR, 32'h06);
    chk("R6 favored pending kept, no reject", 32'(rej_valid), 32'd0);
    chk("R6 irq kept", 32'(irq_out), 32'd1);
    poll_expect("R6 kept poll", 32'h0600_0041, 8'hFF);
    do_op(C_ACCEPT, 32'h0);
    chk("R5 accept 0x41", rd_data, 32'h0600_0041);
    poll_expect("R5 threshold from pending", 32'h0200_0000, 8'hFF);
    do_op(C_EOI, 32'hFF00_0041);
    chk("R9 eoi 0x41", 32'(eoi_src), 32'h41);
  endtask

  task automatic t_ipi;
    do_op(C_IPI, 32'h80);
    chk("R8 ipi raises irq", 32'(irq_out), 32'd1);
    chk("R8 no reject into empty", 32'(rej_valid), 32'd0);
    poll_expect("R8 ipi offered", 32'hFF00_0002, 8'h80);
    do_req(24'h50, 8'h90);
    chk("R3 weaker than IPI rejected", 32'(rej_src), 32'h50);
    do_req(24'h51, 8'h10);
    chk("R4 IPI displaced without reject", 32'(rej_valid), 32'd0);
    poll_expect("R4 device over IPI", 32'hFF00_0051, 8'h80);
    do_op(C_ACCEPT, 32'h0);
    poll_expect("R5 threshold 0x10", 32'h1000_0000, 8'h80);
    do_op(C_EOI, 32'hFF00_0051);
    chk("R10 resend pulse", 32'(resend_valid), 32'd1);
    chk("R10 resend reloads IPI irq", 32'(irq_out), 32'd1);
    poll_expect("R10 IPI re-offered", 32'hFF00_0002, 8'h80);
    do_op(C_ACCEPT, 32'h0);
    do_op(C_IPI, 32'hFF);
    chk("R8 ipi FF no irq", 32'(irq_out), 32'd0);
    poll_expect("R8 ipi stored only", 32'h8000_0000, 8'hFF);
    do_op(C_EOI, 32'hFF00_0002);
    chk("R9 eoi IPI number", 32'(eoi_src), 32'h2);
    chk("R10 no IPI when prio FF", 32'(irq_out), 32'd0);
    do_req(24'h60, 8'h40);
    do_op(C_IPI, 32'h20);
    chk("R8 ipi rejects device", 32'(rej_valid), 32'd1);
    chk("R8 rejected device number", 32'(rej_src), 32'h60);
    poll_expect("R8 ipi over device", 32'hFF00_0002, 8'h20);
    do_op(C_IPI, 32'h30);
    chk("R8 weaker ipi no reject", 32'(rej_valid), 32'd0);
    poll_expect("R8 weaker ipi held off", 32'hFF00_0002, 8'h30);
  endtask

  task automatic t_misc;
    do_op(C_CUR, 32'hFF);
    chk("R7 no resend while busy", 32'(resend_valid), 32'd0);
    do_op(3'd7, 32'h0000_0000);
    chk("R11 no reject", 32'(rej_valid), 32'd0);
    chk("R11 no resend", 32'(resend_valid), 32'd0);
    chk("R11 no eoi", 32'(eoi_valid), 32'd0);
    chk("R11 irq held", 32'(irq_out), 32'd1);
    do_op(3'd5, 32'h0000_0000);
    poll_expect("R11 state untouched", 32'hFF00_0002, 8'h30);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_src = '0; req_prio = '0;
    op_valid = 1'b0; op_code = '0; op_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset;
    t_reject_threshold;
    t_take_displace;
    t_accept_eoi;
    t_threshold_drop;
    t_ipi;
    t_misc;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule